// File: doc/BRIEF.md
# Card Bus Clock Generator

This block derives the clock that drives a memory card bus from the host's system clock. Two cascaded stages do the division. A coarse stage divides by one, or by twice a programmed prescale value. A fine stage divides by its programmed value plus one. The divided clock is a registered output. It is started and stopped only at points where it is low, so the card never sees a shortened high pulse. The block also has a soft-reset command. That command halts the clock at once, restores the slowest setting and sends a one-cycle pulse to the rest of the host.

Software reaches the block through a single 16-bit write port. When `wr_sel` is low the word goes to the command register. When `wr_sel` is high it goes to the rate register. A sequencer has three named states. `CK_OFF` means the clock is parked low. `CK_RUN` means the clock is toggling. `CK_DRAIN` means a stop has been requested and the current period is finishing.

The transitions are as follows:
- `START_GO` moves `CK_OFF` to `CK_RUN`.
- `STOP_REQ` moves `CK_RUN` to `CK_DRAIN`.
- `STOP_CANCEL` moves `CK_DRAIN` back to `CK_RUN`.
- `STOP_DONE` moves `CK_DRAIN` to `CK_OFF` at the end of the period.
- `ABORT` moves any state to `CK_OFF` on soft reset.

Top module: `cardclk_gen`

## Requirements
- R1: After the reset input is released, or after a soft reset, `card_clk`, `clk_running` and `soft_rst` are low. The rate settings are then prescale 0x800 and divider 15, which gives one card clock period every 65536 input clocks, high for the first 32768.
- R2: A rate write (`wr_sel`=1) puts the prescale value P in bits 15:4 and the divider value D in bits 3:0. The card clock period is then (D+1)·M input cycles, where M is 1 when P is 0 and 2·P otherwise.
- R3: Each period begins with a high phase of floor((D+1)/2)·M cycles, and the card clock is low for the rest of the period.
- R4: A divider value of 0 is treated as 1, so the fastest output is the input clock divided by 2.
- R5: A command write (`wr_sel`=0) with bit 1 (start) set and bit 0 clear, made while the clock is stopped, raises `card_clk` and `clk_running` on the same edge that samples the write.
- R6: A command write with bit 0 (stop) set lets the current period finish, including its low phase. `clk_running` then falls, and `card_clk` stays low, at the period boundary. Stop takes priority over start in the same write, and a stop write while the clock is stopped leaves it stopped.
- R7: A start write while the clock is running has no effect on its phase or period. A start write made while a stop is draining cancels the stop.
- R8: A rate write made while the clock runs takes effect at the next period boundary. The period in progress keeps the old values.
- R9: A command write with bit 3 (soft reset) set stops the clock immediately and restores the R1 rate settings. It drives `soft_rst` high for exactly the cycle after the sampling edge. Start and stop bits in the same write are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that is divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_sel | input | 1 | 0 selects the command register, 1 selects the rate register |
| wr_data | input | 16 | Write data |
| card_clk | output | 1 | Divided, gated card bus clock (registered) |
| clk_running | output | 1 | High while the card clock is running or draining |
| soft_rst | output | 1 | One-cycle soft-reset pulse for the rest of the host |

## Verification
Every output is registered. A write sampled on a rising edge is therefore visible on the port from that edge onward: start and soft reset show in the same cycle, and the `soft_rst` pulse lasts exactly one cycle. A stop or a rate change is due exactly on the period boundary that follows, (D+1)·M edges after the last rise. The bench drives inputs and samples outputs on falling edges. A behavioural model, which keeps a single position counter within the period, predicts all three outputs for every cycle and is compared on every falling edge. Directed checks count falling edges from a write to the expected rise or fall, and measure the period and high time of each rate setting.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

    typedef enum logic [1:0] {
        CK_OFF   = 2'd0,
        CK_RUN   = 2'd1,
        CK_DRAIN = 2'd2
    } ck_state_t;

    // command register bit positions
    localparam int CMD_STOP  = 0;
    localparam int CMD_START = 1;
    localparam int CMD_RESET = 3;

endpackage

// File: rtl/cardclk_prescale.sv
module cardclk_prescale #(
    parameter int               PRE_W   = 12,
    parameter logic [PRE_W-1:0] DEF_PRE = 12'h800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             load,
    input  logic [PRE_W-1:0] pre_in,
    output logic             tick
);
    localparam int CNT_W = PRE_W + 1;

    logic [PRE_W-1:0] pre_a;
    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] lim;

    always_comb begin
        if (pre_a == '0) lim = '0;
        else             lim = {pre_a, 1'b0} - CNT_W'(1);
        tick = run && (pcnt == lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt  <= '0;
            pre_a <= DEF_PRE;
        end else begin
            if (restart || !run || tick) pcnt <= '0;
            else                         pcnt <= pcnt + CNT_W'(1);
            if (load) pre_a <= pre_in;
        end
    end

    assert_pcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pcnt <= lim));

endmodule

// File: rtl/cardclk_divide.sv
module cardclk_divide #(
    parameter int               DIV_W   = 4,
    parameter logic [DIV_W-1:0] DEF_DIV = 4'd15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             tick,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    output logic             boundary,
    output logic             hi_nxt
);
    localparam int HW = DIV_W + 1;

    logic [DIV_W-1:0] div_a, div_d, div_fix;
    logic [DIV_W-1:0] dcnt, dcnt_d;
    logic [HW-1:0]    half_d;

    always_comb begin
        div_fix  = (div_in == '0) ? DIV_W'(1) : div_in;
        boundary = tick && (dcnt == div_a);
        div_d    = load ? div_fix : div_a;
        if (restart || !run) dcnt_d = '0;
        else if (boundary)   dcnt_d = '0;
        else if (tick)       dcnt_d = dcnt + DIV_W'(1);
        else                 dcnt_d = dcnt;
        half_d = ({1'b0, div_d} + HW'(1)) >> 1;
        hi_nxt = ({1'b0, dcnt_d} < half_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt  <= '0;
            div_a <= DEF_DIV;
        end else begin
            dcnt  <= dcnt_d;
            div_a <= div_d;
        end
    end

    assert_dcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dcnt <= div_a);
    assert_div_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        div_a != '0);

endmodule

// File: rtl/cardclk_ctrl.sv
module cardclk_ctrl
    import cardclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic bit_stop,
    input  logic bit_start,
    input  logic bit_rst,
    input  logic boundary,
    output logic running,
    output logic nx_running,
    output logic restart,
    output logic srst_req,
    output logic soft_rst
);
    ck_state_t state, nx;
    logic go, halt;

    // next-state process
    always_comb begin
        srst_req = ctl_wr && bit_rst;
        go       = ctl_wr && bit_start && !bit_stop;
        halt     = ctl_wr && bit_stop;
        nx       = state;
        unique case (state)
            CK_OFF:   if (go) nx = CK_RUN;                    // START_GO
            CK_RUN:   if (halt) nx = CK_DRAIN;                // STOP_REQ
            CK_DRAIN: if (go) nx = CK_RUN;                    // STOP_CANCEL
                      else if (boundary) nx = CK_OFF;         // STOP_DONE
            default:  nx = CK_OFF;
        endcase
        if (srst_req) nx = CK_OFF;                            // ABORT
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= CK_OFF;
            soft_rst <= 1'b0;
        end else begin
            state    <= nx;
            soft_rst <= srst_req;
        end
    end

    // output process
    always_comb begin
        running    = (state != CK_OFF);
        nx_running = (nx != CK_OFF);
        restart    = srst_req || ((state == CK_OFF) && go);
    end

    assert_srst_parks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (state == CK_OFF));
    assert_drain_at_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state) == CK_DRAIN) && (state == CK_OFF) && !soft_rst) |-> $past(boundary));

endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
    import cardclk_pkg::*;
#(
    parameter int               PRE_W   = 12,
    parameter int               DIV_W   = 4,
    parameter logic [PRE_W-1:0] DEF_PRE = 12'h800,
    parameter logic [DIV_W-1:0] DEF_DIV = 4'd15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_sel,
    input  logic [PRE_W+DIV_W-1:0] wr_data,
    output logic                   card_clk,
    output logic                   clk_running,
    output logic                   soft_rst
);
    localparam int WD_W = PRE_W + DIV_W;

    logic             ctl_wr, rate_wr;
    logic             nx_running, restart, srst_req;
    logic             tick, boundary, hi_nxt, load;
    logic [PRE_W-1:0] pre_prog, pre_ld;
    logic [DIV_W-1:0] div_prog, div_ld;
    logic             card_clk_q;

    always_comb begin
        ctl_wr  = wr_en && !wr_sel;
        rate_wr = wr_en && wr_sel;
        load    = restart || boundary;
        pre_ld  = srst_req ? DEF_PRE : pre_prog;
        div_ld  = srst_req ? DEF_DIV : div_prog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_prog   <= DEF_PRE;
            div_prog   <= DEF_DIV;
            card_clk_q <= 1'b0;
        end else begin
            if (srst_req) begin
                pre_prog <= DEF_PRE;
                div_prog <= DEF_DIV;
            end else if (rate_wr) begin
                pre_prog <= wr_data[WD_W-1:DIV_W];
                div_prog <= wr_data[DIV_W-1:0];
            end
            card_clk_q <= nx_running && hi_nxt;
        end
    end

    cardclk_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .bit_stop   (wr_data[CMD_STOP]),
        .bit_start  (wr_data[CMD_START]),
        .bit_rst    (wr_data[CMD_RESET]),
        .boundary   (boundary),
        .running    (clk_running),
        .nx_running (nx_running),
        .restart    (restart),
        .srst_req   (srst_req),
        .soft_rst   (soft_rst)
    );

    cardclk_prescale #(.PRE_W(PRE_W), .DEF_PRE(DEF_PRE)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (clk_running),
        .restart (restart),
        .load    (load),
        .pre_in  (pre_ld),
        .tick    (tick)
    );

    cardclk_divide #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (clk_running),
        .restart  (restart),
        .tick     (tick),
        .load     (load),
        .div_in   (div_ld),
        .boundary (boundary),
        .hi_nxt   (hi_nxt)
    );

    assign card_clk = card_clk_q;

    assert_gated_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_running |-> !card_clk);
    assert_start_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_running) |-> card_clk);
    assert_stop_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(clk_running) && !soft_rst) |-> !$past(card_clk));

endmodule

// File: tb/tb_cardclk_gen.sv
`timescale 1ns/1ps
module tb_cardclk_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        card_clk, clk_running, soft_rst;

    int total = 0;
    int bad = 0;
    bit armed = 0;

    always #2.5 clk = ~clk;

    cardclk_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .card_clk(card_clk), .clk_running(clk_running),
        .soft_rst(soft_rst)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: one position counter across the whole period
    int m_st = 0, m_pos = 0, m_n = 16, m_m = 4096, m_pp = 2048, m_pd = 15;
    int m_srst = 0;
    int o_pp, o_pd, ns;
    bit cw, rw, sr, go, halt, bnd;

    function automatic int mult(input int p);
        return (p == 0) ? 1 : 2 * p;
    endfunction
    function automatic int ncnt(input int d);
        return ((d == 0) ? 1 : d) + 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pos = 0; m_n = 16; m_m = 4096; m_pp = 2048; m_pd = 15; m_srst = 0;
        end else begin
            cw   = wr_en && !wr_sel;
            rw   = wr_en && wr_sel;
            sr   = cw && wr_data[3];
            go   = cw && wr_data[1] && !wr_data[0];
            halt = cw && wr_data[0];
            bnd  = (m_st != 0) && (m_pos == m_n * m_m - 1);
            o_pp = m_pp; o_pd = m_pd;
            m_srst = sr ? 1 : 0;
            if (sr) begin
                m_st = 0; m_pos = 0; m_pp = 2048; m_pd = 15; m_n = 16; m_m = 4096;
            end else begin
                ns = m_st;
                case (m_st)
                    0: if (go) ns = 1;
                    1: if (halt) ns = 2;
                    default: if (go) ns = 1; else if (bnd) ns = 0;
                endcase
                if (m_st == 0) begin
                    if (ns == 1) begin m_pos = 0; m_n = ncnt(o_pd); m_m = mult(o_pp); end
                end else if (bnd) begin
                    m_pos = 0; m_n = ncnt(o_pd); m_m = mult(o_pp);
                end else begin
                    m_pos++;
                end
                m_st = ns;
                if (ns == 0) m_pos = 0;
                if (rw) begin m_pp = int'(wr_data[15:4]); m_pd = int'(wr_data[3:0]); end
            end
        end
    end

    always @(negedge clk) begin
        if (armed) begin
            int exp_clk;
            exp_clk = (m_st != 0 && m_pos < (m_n / 2) * m_m) ? 1 : 0;
            check(int'(card_clk) == exp_clk, "R3 card_clk per-cycle", int'(card_clk), exp_clk);
            check(int'(clk_running) == ((m_st != 0) ? 1 : 0), "R6 clk_running per-cycle",
                  int'(clk_running), (m_st != 0) ? 1 : 0);
            check(int'(soft_rst) == m_srst, "R9 soft_rst per-cycle", int'(soft_rst), m_srst);
        end
    end

    task automatic wr(input bit sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_rise();
        logic prev;
        prev = card_clk;
        forever begin
            @(negedge clk);
            if (card_clk && !prev) break;
            prev = card_clk;
        end
    endtask

    task automatic measure_from_high(output int per, output int hi);
        logic prev;
        per = 0; hi = 1; prev = 1'b1;
        forever begin
            @(negedge clk);
            per++;
            if (card_clk && !prev) break;
            if (card_clk) hi++;
            prev = card_clk;
        end
    endtask

    task automatic measure(input int exp_per, input int exp_hi, input string tp, input string th);
        int per, hi;
        wait_rise();
        measure_from_high(per, hi);
        check(per == exp_per, tp, per, exp_per);
        check(hi == exp_hi, th, hi, exp_hi);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, per, hi;
        logic prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        armed = 1;
        @(negedge clk);
        // R1 reset state
        check(card_clk == 1'b0, "R1 reset card_clk", int'(card_clk), 0);
        check(clk_running == 1'b0, "R1 reset clk_running", int'(clk_running), 0);
        check(soft_rst == 1'b0, "R1 reset soft_rst", int'(soft_rst), 0);

        // R2 fastest rate, R5 start
        wr(1'b1, 16'h0001);
        wr(1'b0, 16'h0002);
        check(card_clk == 1'b1, "R5 start raises card_clk", int'(card_clk), 1);
        check(clk_running == 1'b1, "R5 start raises clk_running", int'(clk_running), 1);
        measure(2, 1, "R2 period P0 D1", "R3 high P0 D1");

        // R8 rate change while running waits for the boundary
        wait_rise();
        wr(1'b1, 16'h0013);
        n = 1; prev = card_clk;
        forever begin
            @(negedge clk); n++;
            if (card_clk && !prev) break;
            prev = card_clk;
        end
        check(n == 2, "R8 old period completes", n, 2);
        measure(8, 4, "R8 new period P1 D3", "R3 high P1 D3");

        // R7 repeated start has no effect
        for (int i = 0; i < 8; i++) wr(1'b0, 16'h0002);
        measure(8, 4, "R7 period after repeated start", "R7 high after repeated start");

        // R6 stop completes the period
        wait_rise();
        wr(1'b0, 16'h0001);
        n = 1;
        while (clk_running) begin @(negedge clk); n++; end
        check(n == 8, "R6 stop at boundary", n, 8);
        check(card_clk == 1'b0, "R6 parked low", int'(card_clk), 0);
        wr(1'b0, 16'h0003);
        check(clk_running == 1'b0, "R6 stop wins over start", int'(clk_running), 0);

        // R4 divider zero
        wr(1'b1, 16'h0000);
        wr(1'b0, 16'h0002);
        check(card_clk == 1'b1, "R5 restart raises card_clk", int'(card_clk), 1);
        measure(2, 1, "R4 period D0", "R4 high D0");

        // R2 R3 larger prescale
        wr(1'b1, 16'h0044);
        measure(40, 16, "R2 period P4 D4", "R3 high P4 D4");

        // R7 start during drain cancels stop
        wr(1'b0, 16'h0001);
        wr(1'b0, 16'h0002);
        check(clk_running == 1'b1, "R7 drain cancelled", int'(clk_running), 1);
        measure(40, 16, "R7 period after cancel", "R7 high after cancel");

        wr(1'b1, 16'h0022);
        measure(12, 4, "R2 period P2 D2", "R3 high P2 D2");

        // R9 soft reset
        wr(1'b0, 16'h0008);
        check(soft_rst == 1'b1, "R9 pulse high", int'(soft_rst), 1);
        check(clk_running == 1'b0, "R9 stops running", int'(clk_running), 0);
        check(card_clk == 1'b0, "R9 card_clk low", int'(card_clk), 0);
        @(negedge clk);
        check(soft_rst == 1'b0, "R9 pulse one cycle", int'(soft_rst), 0);
        wr(1'b0, 16'h000A);
        check(clk_running == 1'b0, "R9 start ignored with reset", int'(clk_running), 0);
        wr(1'b0, 16'h0002);
        check(card_clk == 1'b1, "R5 start after reset", int'(card_clk), 1);
        measure_from_high(per, hi);
        check(per == 65536, "R1 default period", per, 65536);
        check(hi == 32768, "R1 default high", hi, 32768);

        armed = 0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule